// File: doc/BRIEF.md
# Battery-Backed Key Vault Controller

This block keeps a 256-bit secret as eight 32-bit words that software can write but never read back, plus one general-purpose auxiliary word. The key can only be written after a special unlock value has been stored to the unlock register. Storing that value also wipes the key. Software can wipe the key again at any time through a self-clearing command bit. A zeroized flag records whether the key is currently blank.

To confirm a key load, software writes the checksum it expects. A background engine then computes a reflected CRC-32C over the stored words. It uses polynomial 0x82F63B78, an initial value of zero and no final XOR, and takes one word per clock from word 7 down to word 0. When the run ends, the engine raises a done flag and a pass flag.

The auxiliary word has a sticky lock and a build option that makes it write-only. Bus accesses to holes in the map, or with a size other than a word, can be reported as bus errors through one maskable interrupt. The block has two resets. Power-on reset clears everything. Functional reset restores the control state and leaves the key, the auxiliary word, the unlock state, the lock and the zeroized flag untouched.

Top module: `keyvault_top`

## Requirements
- R1: After power-on reset the status register (0x00) reads 0, the auxiliary word (0x30) and lock (0x4C) read 0, `irq` is low, and `busReady` is always 1 (no wait states). An access happens in the cycle where `busSel` and `busEnable` are both high.
- R2: Writing exactly 0x757BDF0D to the unlock register (0x08) zeroizes the key and sets status bit 0 (programming mode). Any other value has no effect. Bit 0 falls only on power-on reset.
- R3: Writes to key words 0..7 (0x10 + 4*i) are dropped while status bit 0 is clear. Key words and the checksum register (0x0C) always read 0.
- R4: Writing 1 to bit 0 of the command register (0x04) zeroizes, and the bit reads back 0. Zeroizing clears key words 0..7, clears the auxiliary word only when the write-only option is set, and sets status bit 4.
- R5: An accepted nonzero store to a key word clears status bit 4. An accepted nonzero store to the auxiliary word clears it only when the write-only option is set.
- R6: A checksum write while status bit 0 is set records the expected value, clears status bits 8 and 9, and starts the engine. The engine takes the key words from 7 down to 0 (an optional leading zero word can be added as a build option). Bit 8 (done) sets 8 clocks after the write edge, and bit 9 (pass) then shows whether the computed CRC equals the expected value. A checksum write outside programming mode changes nothing.
- R7: A checksum write that lands while a run is active, including on its final cycle, restarts the run. Done stays clear until the new run finishes.
- R8: The auxiliary word accepts writes only when programming mode is set and the lock is clear. It reads back its value, or 0 when the write-only option is set.
- R9: Lock bit 0 (0x4C) can be set but not cleared by software. Only power-on reset clears it, and it never sets when the write-only option is set.
- R10: An access to an unmapped offset (0x48, anything above 0x4C, or an address not aligned to a word) or with `busSize` not equal to 2'b10 has no effect and reads 0. If bit 0 of the error-enable register (0x34) is set, the access also returns `busErr` = 1 and sets interrupt-status bit 0 (0x38).
- R11: `irq` equals interrupt-status bit 0 AND NOT mask bit 0 (0x3C). Interrupt status is cleared by writing 1. Writing 1 to the enable register (0x40) clears the mask, and writing 1 to the disable register (0x44) sets it. Both of those registers read 0, and the mask register ignores writes.
- R12: Functional reset clears error-enable, interrupt status, mask, done and pass. It keeps the key, the auxiliary word, programming mode, the lock and the zeroized flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| funcRstN | input | 1 | Functional reset, asynchronous, active low |
| busSel | input | 1 | Select (setup and access phases) |
| busEnable | input | 1 | Access phase |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busSize | input | 2 | Access size, 2'b10 = 32-bit word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| busReady | output | 1 | Always high |
| busErr | output | 1 | Error response in the access cycle |
| irq | output | 1 | Error interrupt |

## Verification
The checksum engine's final step and a fresh checksum write can fall on the same clock edge. The edge can either report the old result or start a new run, and the restart must win. The bench first writes a wrong checksum. It then waits idle cycles so that a correct checksum write is accepted on exactly the eighth edge after the first. A status read right afterwards must show done clear, not the stale failed result, and once the restarted run completes the status must show done and pass.

// File: rtl/keyvault_pkg.sv
package keyvault_pkg;
  localparam int DATA_W    = 32;
  localparam int KEY_WORDS = 8;
  localparam int KIDX_W    = $clog2(KEY_WORDS);

  localparam logic [31:0] UNLOCK_CODE = 32'h757B_DF0D;
  localparam logic [31:0] CRC_POLY    = 32'h82F6_3B78;
  localparam logic [1:0]  SIZE_WORD   = 2'b10;

  // word indices (byte offset / 4)
  localparam logic [4:0] REG_STATUS = 5'd0;
  localparam logic [4:0] REG_CMD    = 5'd1;
  localparam logic [4:0] REG_UNLOCK = 5'd2;
  localparam logic [4:0] REG_CHECK  = 5'd3;
  localparam logic [4:0] REG_KEY0   = 5'd4;
  localparam logic [4:0] REG_KEYN   = 5'(4 + KEY_WORDS - 1);
  localparam logic [4:0] REG_AUX    = 5'd12;
  localparam logic [4:0] REG_ERREN  = 5'd13;
  localparam logic [4:0] REG_ISR    = 5'd14;
  localparam logic [4:0] REG_IMR    = 5'd15;
  localparam logic [4:0] REG_IEN    = 5'd16;
  localparam logic [4:0] REG_IDIS   = 5'd17;
  localparam logic [4:0] REG_LOCK   = 5'd19;

  typedef struct packed {
    logic              keyWe;
    logic [KIDX_W-1:0] keyIdx;
    logic              auxWe;
    logic              zeroize;
    logic              crcStart;
    logic [DATA_W-1:0] wdata;
  } dpStrobe_t;

  // one 32-bit word through a reflected CRC, LSB first
  function automatic logic [31:0] crcWordStep(input logic [31:0] acc, input logic [31:0] word);
    logic [31:0] r;
    r = acc;
    for (int b = 0; b < 32; b++) begin
      if (r[0] ^ word[b]) r = (r >> 1) ^ CRC_POLY;
      else                r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/keyvault_datapath.sv
module keyvault_datapath
  import keyvault_pkg::*;
#(
  parameter bit EXTRA_WO = 1'b0,
  parameter bit CRC_PAD  = 1'b0
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        ctrlRstN,
  input  dpStrobe_t   st,
  output logic [31:0] auxData,
  output logic        crcLast,
  output logic [31:0] crcNext
);
  localparam int PAD_N = CRC_PAD ? 1 : 0;
  localparam int STEPS = KEY_WORDS + PAD_N;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic [31:0] keyMem [KEY_WORDS];
  logic [31:0] auxReg;
  logic             busy;
  logic [CNT_W-1:0] stepCnt;
  logic [31:0]      crcAcc;
  logic [31:0]      curWord;
  int               wordSel;

  // key words and auxiliary word live only under power-on reset
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      for (int i = 0; i < KEY_WORDS; i++) keyMem[i] <= '0;
      auxReg <= '0;
    end else begin
      if (st.zeroize) begin
        for (int i = 0; i < KEY_WORDS; i++) keyMem[i] <= '0;
      end else if (st.keyWe) begin
        keyMem[st.keyIdx] <= st.wdata;
      end
      if (st.zeroize && EXTRA_WO) auxReg <= '0;
      else if (st.auxWe)          auxReg <= st.wdata;
    end
  end

  assign auxData = auxReg;

  // word order: optional zero pad, then key word 7 down to 0
  always_comb begin
    curWord = '0;
    wordSel = KEY_WORDS - 1 - int'(stepCnt) + PAD_N;
    if (wordSel >= 0 && wordSel < KEY_WORDS) curWord = keyMem[wordSel[KIDX_W-1:0]];
  end

  assign crcNext = crcWordStep(crcAcc, curWord);
  assign crcLast = busy && (stepCnt == CNT_W'(STEPS - 1));

  always_ff @(posedge clk or negedge ctrlRstN) begin
    if (!ctrlRstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
      crcAcc  <= '0;
    end else if (st.crcStart) begin
      busy    <= 1'b1;
      stepCnt <= '0;
      crcAcc  <= '0;
    end else if (busy) begin
      crcAcc  <= crcNext;
      stepCnt <= stepCnt + 1'b1;
      if (crcLast) busy <= 1'b0;
    end
  end

  assert_restart_R7: assert property (@(posedge clk) disable iff (!ctrlRstN)
    st.crcStart |=> (busy && stepCnt == '0 && crcAcc == '0));

  assert_key_hold_R3: assert property (@(posedge clk) disable iff (!porRstN)
    (!st.keyWe && !st.zeroize) |=> $stable(keyMem[0]));
endmodule

// File: rtl/keyvault_control.sv
module keyvault_control
  import keyvault_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter bit EXTRA_WO = 1'b0
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              ctrlRstN,
  input  logic              busSel,
  input  logic              busEnable,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busErr,
  output logic              irq,
  output dpStrobe_t         st,
  input  logic [31:0]       auxData,
  input  logic              crcLast,
  input  logic [31:0]       crcNext
);
  logic       access, mapped, badAccess, errHit, goodWr, goodRd, isKey, magicHit;
  logic [4:0] regSel;
  logic       pgmMode, lockBit, zeroized;
  logic       errEn, isrBit, imrBit, crcDone, crcPass;
  logic [31:0] expected;

  assign access    = busSel & busEnable;
  assign regSel    = busAddr[6:2];
  assign mapped    = ((busAddr >> 7) == '0) && (busAddr[1:0] == 2'b00) &&
                     ((regSel <= REG_IDIS) || (regSel == REG_LOCK));
  assign badAccess = access && (!mapped || busSize != SIZE_WORD);
  assign errHit    = badAccess && errEn;
  assign goodWr    = access && busWrite && !badAccess;
  assign goodRd    = access && !busWrite && !badAccess;
  assign isKey     = (regSel >= REG_KEY0) && (regSel <= REG_KEYN);
  assign magicHit  = goodWr && regSel == REG_UNLOCK && busWdata == UNLOCK_CODE;

  always_comb begin
    st.wdata    = busWdata;
    st.keyIdx   = KIDX_W'(regSel - REG_KEY0);
    st.keyWe    = goodWr && isKey && pgmMode;
    st.auxWe    = goodWr && regSel == REG_AUX && pgmMode && !lockBit;
    st.zeroize  = (goodWr && regSel == REG_CMD && busWdata[0]) || magicHit;
    st.crcStart = goodWr && regSel == REG_CHECK && pgmMode;
  end

  // state that only power-on reset may clear
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      pgmMode  <= 1'b0;
      lockBit  <= 1'b0;
      zeroized <= 1'b0;
    end else begin
      if (magicHit) pgmMode <= 1'b1;
      if (goodWr && regSel == REG_LOCK && busWdata[0] && !EXTRA_WO) lockBit <= 1'b1;
      if (st.zeroize) zeroized <= 1'b1;
      else if ((st.keyWe || (st.auxWe && EXTRA_WO)) && busWdata != '0) zeroized <= 1'b0;
    end
  end

  // control state restored by either reset
  always_ff @(posedge clk or negedge ctrlRstN) begin
    if (!ctrlRstN) begin
      errEn    <= 1'b0;
      isrBit   <= 1'b0;
      imrBit   <= 1'b0;
      crcDone  <= 1'b0;
      crcPass  <= 1'b0;
      expected <= '0;
    end else begin
      if (goodWr && regSel == REG_ERREN) errEn <= busWdata[0];
      if (errHit) isrBit <= 1'b1;
      else if (goodWr && regSel == REG_ISR && busWdata[0]) isrBit <= 1'b0;
      if (goodWr && regSel == REG_IEN && busWdata[0])  imrBit <= 1'b0;
      if (goodWr && regSel == REG_IDIS && busWdata[0]) imrBit <= 1'b1;
      if (st.crcStart) begin
        crcDone  <= 1'b0;
        crcPass  <= 1'b0;
        expected <= busWdata;
      end else if (crcLast) begin
        crcDone <= 1'b1;
        crcPass <= (crcNext == expected);
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (goodRd) begin
      case (regSel)
        REG_STATUS: busRdata = {22'b0, crcPass, crcDone, 3'b0, zeroized, 3'b0, pgmMode};
        REG_AUX:    busRdata = EXTRA_WO ? 32'h0 : auxData;
        REG_ERREN:  busRdata = {31'b0, errEn};
        REG_ISR:    busRdata = {31'b0, isrBit};
        REG_IMR:    busRdata = {31'b0, imrBit};
        REG_LOCK:   busRdata = {31'b0, lockBit};
        default:    busRdata = '0;
      endcase
    end
  end

  assign busErr = errHit;
  assign irq    = isrBit & ~imrBit;

  assert_pgm_sticky_R2: assert property (@(posedge clk) disable iff (!porRstN)
    pgmMode |=> pgmMode);
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!porRstN)
    lockBit |=> lockBit);
  assert_err_latch_R10: assert property (@(posedge clk) disable iff (!ctrlRstN)
    busErr |=> isrBit);
  assert_bad_inert_R10: assert property (@(posedge clk) disable iff (!porRstN)
    badAccess |=> ($stable(pgmMode) && $stable(lockBit)));
  assert_mask_quiet_R11: assert property (@(posedge clk) disable iff (!ctrlRstN)
    (goodWr && regSel == REG_IDIS && busWdata[0]) |=> !irq);
  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!ctrlRstN)
    st.crcStart |=> !crcDone);

  generate
    if (EXTRA_WO) begin : g_woLock
      assert_lock_never_R9: assert property (@(posedge clk) disable iff (!porRstN) !lockBit);
    end
  endgenerate
endmodule

// File: rtl/keyvault_top.sv
module keyvault_top
  import keyvault_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter bit EXTRA_WO = 1'b0,
  parameter bit CRC_PAD  = 1'b0
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              funcRstN,
  input  logic              busSel,
  input  logic              busEnable,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busReady,
  output logic              busErr,
  output logic              irq
);
  logic        ctrlRstN;
  dpStrobe_t   st;
  logic [31:0] auxData;
  logic        crcLast;
  logic [31:0] crcNext;

  assign ctrlRstN = porRstN & funcRstN;
  assign busReady = 1'b1;

  keyvault_control #(.ADDR_W(ADDR_W), .EXTRA_WO(EXTRA_WO)) ctrl_i (
    .clk(clk), .porRstN(porRstN), .ctrlRstN(ctrlRstN),
    .busSel(busSel), .busEnable(busEnable), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr), .irq(irq),
    .st(st), .auxData(auxData), .crcLast(crcLast), .crcNext(crcNext)
  );

  keyvault_datapath #(.EXTRA_WO(EXTRA_WO), .CRC_PAD(CRC_PAD)) dp_i (
    .clk(clk), .porRstN(porRstN), .ctrlRstN(ctrlRstN), .st(st),
    .auxData(auxData), .crcLast(crcLast), .crcNext(crcNext)
  );
endmodule

// File: tb/keyvault_top_tb_top.sv
module keyvault_top_tb_top;
  localparam logic [7:0] A_STATUS = 8'h00, A_CMD = 8'h04, A_UNLOCK = 8'h08, A_CHECK = 8'h0C,
                         A_KEY0 = 8'h10, A_AUX = 8'h30, A_ERREN = 8'h34, A_ISR = 8'h38,
                         A_IMR = 8'h3C, A_IEN = 8'h40, A_IDIS = 8'h44, A_HOLE = 8'h48,
                         A_LOCK = 8'h4C;
  localparam logic [1:0] SZ = 2'b10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic porRstN = 1'b0, funcRstN = 1'b0;
  logic busSel = 1'b0, busEnable = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [1:0]  busSize = SZ;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busReady, busErr, irq;

  keyvault_top dut_i (
    .clk(clk), .porRstN(porRstN), .funcRstN(funcRstN),
    .busSel(busSel), .busEnable(busEnable), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .busErr(busErr), .irq(irq)
  );

  int totalCnt = 0, failCnt = 0;
  logic [31:0] lastRd;
  logic [31:0] keyModel [8];

  // scoreboard: mode 0 = no compare, 1 = error only, 2 = error and data
  int          expMode[$];
  logic [31:0] expData[$];
  logic        expErr[$];
  string       expTag[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (busSel && busEnable) begin : mon
      int m; logic [31:0] d; logic e; string t;
      lastRd = busRdata;
      if (expMode.size() != 0) begin
        m = expMode.pop_front(); d = expData.pop_front();
        e = expErr.pop_front(); t = expTag.pop_front();
        if (m >= 1) check({t, " err"}, {31'b0, busErr}, {31'b0, e});
        if (m == 2) check({t, " data"}, busRdata, d);
      end
    end
  end

  task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [1:0] sz, input int m, input logic [31:0] ed,
                      input logic ee, input string tag);
    expMode.push_back(m); expData.push_back(ed); expErr.push_back(ee); expTag.push_back(tag);
    @(posedge clk); #1;
    busSel = 1'b1; busEnable = 1'b0; busWrite = wr; busAddr = a; busWdata = d; busSize = sz;
    @(posedge clk); #1;
    busEnable = 1'b1;
    @(posedge clk); #1;
    busSel = 1'b0; busEnable = 1'b0; busWrite = 1'b0; busSize = SZ;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    xfer(1'b1, a, d, SZ, 1, '0, 1'b0, tag);
  endtask
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    xfer(1'b0, a, '0, SZ, 2, e, 1'b0, tag);
  endtask
  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    xfer(1'b0, a, '0, SZ, 0, '0, 1'b0, "peek");
    v = lastRd;
  endtask
  task automatic checkIrq(input logic e, input string tag);
    @(negedge clk);
    check(tag, {31'b0, irq}, {31'b0, e});
  endtask
  task automatic waitDone();
    logic [31:0] v;
    for (int i = 0; i < 40; i++) begin
      peek(A_STATUS, v);
      if (v[8]) break;
    end
  endtask

  function automatic logic [31:0] refCrc();
    logic [31:0] c; logic fb;
    c = '0;
    for (int w = 7; w >= 0; w--) begin
      for (int b = 0; b < 32; b++) begin
        fb = c[0] ^ keyModel[w][b];
        c = c >> 1;
        if (fb) c = c ^ 32'h82F6_3B78;
      end
    end
    return c;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failCnt++; totalCnt++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin : main
    logic [31:0] crc;
    for (int i = 0; i < 8; i++) keyModel[i] = '0;
    repeat (5) @(posedge clk);
    #1 porRstN = 1'b1; funcRstN = 1'b1;

    // R1 reset state
    rd(A_STATUS, 32'h0, "R1 status after reset");
    checkIrq(1'b0, "R1 irq after reset");
    check("R1 ready", {31'b0, busReady}, 32'h1);

    // R4 zeroize command
    wr(A_CMD, 32'h1, "R4 cmd");
    rd(A_STATUS, 32'h10, "R4 zeroized flag");
    rd(A_CMD, 32'h0, "R4 self clear");

    // R3 key write dropped outside programming mode
    wr(A_KEY0, 32'h1234, "R3 key wr locked");
    rd(A_STATUS, 32'h10, "R3 key write ignored");

    // R6 checksum write outside programming mode
    wr(A_CHECK, 32'h0, "R6 check locked");
    repeat (12) @(posedge clk);
    rd(A_STATUS, 32'h10, "R6 no run outside pgm");

    // R2 unlock
    wr(A_UNLOCK, 32'h757B_DF0C, "R2 wrong code");
    rd(A_STATUS, 32'h10, "R2 wrong code ignored");
    wr(A_UNLOCK, 32'h757B_DF0D, "R2 magic");
    rd(A_STATUS, 32'h11, "R2 pgm set");

    // R5 / R3 key loading
    for (int i = 0; i < 8; i++) begin
      keyModel[i] = 32'h9E37_79B9 * 32'(i + 1);
      wr(A_KEY0 + 8'(4 * i), keyModel[i], "R3 key load");
    end
    rd(A_STATUS, 32'h01, "R5 zeroized cleared");
    rd(A_KEY0 + 8'd12, 32'h0, "R3 key reads zero");

    // R6 good checksum, done not early
    crc = refCrc();
    wr(A_CHECK, crc, "R6 check good");
    rd(A_STATUS, 32'h01, "R6 done not yet");
    waitDone();
    rd(A_STATUS, 32'h301, "R6 done and pass");
    rd(A_CHECK, 32'h0, "R3 check reads zero");

    // R6 bad checksum
    wr(A_CHECK, crc ^ 32'h1, "R6 check bad");
    waitDone();
    rd(A_STATUS, 32'h101, "R6 done no pass");

    // R7 restart on the finishing edge
    wr(A_CHECK, crc ^ 32'h1, "R7 first");
    repeat (5) @(posedge clk);
    wr(A_CHECK, crc, "R7 second");
    rd(A_STATUS, 32'h001, "R7 restart wins");
    waitDone();
    rd(A_STATUS, 32'h301, "R7 restarted result");

    // R8 / R4 / R5 auxiliary word
    wr(A_AUX, 32'hCAFE_0008, "R8 aux wr");
    rd(A_AUX, 32'hCAFE_0008, "R8 aux readback");
    wr(A_CMD, 32'h1, "R4 cmd again");
    for (int i = 0; i < 8; i++) keyModel[i] = '0;
    rd(A_STATUS, 32'h311, "R4 zeroized set");
    rd(A_AUX, 32'hCAFE_0008, "R4 aux kept");
    wr(A_CHECK, refCrc(), "R4 check zero key");
    waitDone();
    rd(A_STATUS, 32'h311, "R4 key cleared");
    wr(A_AUX, 32'h55, "R5 aux wr");
    rd(A_STATUS, 32'h311, "R5 aux store keeps zeroized");
    rd(A_AUX, 32'h55, "R8 aux value");

    // R9 lock
    wr(A_LOCK, 32'h1, "R9 lock");
    rd(A_LOCK, 32'h1, "R9 lock set");
    wr(A_AUX, 32'h77, "R8 aux locked wr");
    rd(A_AUX, 32'h55, "R8 locked aux unchanged");
    wr(A_LOCK, 32'h0, "R9 unlock try");
    rd(A_LOCK, 32'h1, "R9 lock sticky");

    // R10 / R11 errors and interrupt
    xfer(1'b0, A_HOLE, '0, SZ, 2, 32'h0, 1'b0, "R10 hole no errEn");
    rd(A_ISR, 32'h0, "R10 isr quiet");
    wr(A_ERREN, 32'h1, "R10 errEn");
    rd(A_ERREN, 32'h1, "R10 errEn readback");
    xfer(1'b0, A_HOLE, '0, SZ, 1, '0, 1'b1, "R10 hole error");
    rd(A_ISR, 32'h1, "R10 isr set");
    checkIrq(1'b1, "R11 irq on");
    wr(A_IDIS, 32'h1, "R11 disable");
    rd(A_IMR, 32'h1, "R11 mask set");
    checkIrq(1'b0, "R11 irq masked");
    rd(A_IDIS, 32'h0, "R11 disable reads zero");
    wr(A_IEN, 32'h1, "R11 enable");
    rd(A_IMR, 32'h0, "R11 mask clear");
    checkIrq(1'b1, "R11 irq unmasked");
    wr(A_IMR, 32'h1, "R11 mask wr");
    rd(A_IMR, 32'h0, "R11 mask read-only");
    wr(A_ISR, 32'h1, "R11 w1c");
    rd(A_ISR, 32'h0, "R11 isr cleared");
    checkIrq(1'b0, "R11 irq off");
    xfer(1'b1, A_KEY0, 32'h1, 2'b01, 1, '0, 1'b1, "R10 bad size");
    xfer(1'b0, 8'h11, '0, SZ, 1, '0, 1'b1, "R10 unaligned");
    xfer(1'b0, 8'h50, '0, SZ, 1, '0, 1'b1, "R10 beyond map");
    rd(A_STATUS, 32'h311, "R10 bad size write ignored");

    // R12 functional reset
    wr(A_IDIS, 32'h1, "R12 prep mask");
    keyModel[0] = 32'hDEAD_BEEF;
    wr(A_KEY0, keyModel[0], "R12 prep key");
    @(posedge clk); #1 funcRstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 funcRstN = 1'b1;
    rd(A_ERREN, 32'h0, "R12 errEn cleared");
    rd(A_ISR, 32'h0, "R12 isr cleared");
    rd(A_IMR, 32'h0, "R12 mask cleared");
    rd(A_STATUS, 32'h001, "R12 status kept pgm");
    rd(A_LOCK, 32'h1, "R12 lock kept");
    rd(A_AUX, 32'h55, "R12 aux kept");
    wr(A_CHECK, refCrc(), "R12 check");
    waitDone();
    rd(A_STATUS, 32'h301, "R12 key kept");

    // R1 / R9 power-on reset
    @(posedge clk); #1 porRstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 porRstN = 1'b1;
    rd(A_STATUS, 32'h0, "R1 status after por");
    rd(A_LOCK, 32'h0, "R9 lock cleared by por");
    rd(A_AUX, 32'h0, "R1 aux cleared by por");

    repeat (3) @(posedge clk);
    if (expMode.size() != 0) check("R1 scoreboard drained", 32'(expMode.size()), 32'h0);
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule